// File: doc/BRIEF.md
# Bounded Cascadable Up-Counter

This block is a small synchronous binary up-counter (four bits by default) whose count range can be narrowed at either end. A programmable first value is reloaded whenever the sequence wraps, and a programmable last value is found by an equality compare on the count. Together they let the counter run from any first value to any last value and then start over. When both bounds are switched off it is a plain modulo-2^W counter.

The core also has a synchronous clear and a synchronous parallel load. It drives a carry output that is high only while the count is all ones and counting is enabled. Feeding that carry into the count enable of a second core makes a wider counter, one nibble per stage. Every state change happens on the rising clock edge. A clear overrides a load, and a load overrides counting.

Top module: `ofs_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes zero; after that edge `carry` is low.
- R2: `clear` high at an edge sets `count` to zero, whatever `load`, `enable` and the bounds are.
- R3: With `clear` low, `load` high at an edge copies `loadVal` into `count`, whether `enable` is high or low; bit W-1 of `loadVal` is the most significant bit of the count.
- R4: With `clear`, `load` and `enable` all low, `count` keeps its value across the edge.
- R5: With `enable` high and no terminal condition (R7–R9), `count` goes up by one at each edge; with both bounds off, all ones goes to zero.
- R6: `carry` is 1 exactly when `count` is all ones and `enable` is 1.
- R7: With `startEn`=1 and `endEn`=0, an enabled edge at all ones loads `startVal`.
- R8: With `endEn`=1 and `startEn`=0, an enabled edge at `count`==`endVal` gives zero. A count above `endVal` keeps counting up to all ones and then rolls to zero.
- R9: With both bounds on, an enabled edge at `count`==`endVal` loads `startVal`; this takes precedence over the all-ones rule.
- R10: Two cores chained, with the upper core's `enable` taken from the lower core's `carry`, form a counter twice as wide. It increments once per enabled cycle and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear to zero |
| load | input | 1 | Synchronous parallel load of `loadVal` |
| enable | input | 1 | Count enable |
| loadVal | input | W | Parallel load value, MSB at bit W-1 |
| startEn | input | 1 | Turns on the first-value bound |
| startVal | input | W | First value of the bounded sequence |
| endEn | input | 1 | Turns on the last-value bound |
| endVal | input | W | Last value of the bounded sequence |
| count | output | W | Current count |
| carry | output | 1 | All ones while enabled, for chaining |

## Verification
The bench drives the wrap edges directly. It checks the all-ones-to-first-value reload, the last-value-to-zero return, and the both-bounds case where the compare must beat the all-ones rule; a design with the wrong precedence would skip the first value or run on to all ones. It also sets clear, load and enable at the same time: if the priority were reversed, the count would take the load value or increment instead of going to zero. In the chained counter, a carry that is not qualified by enable would let the upper nibble advance while the lower one is stalled at all ones.

// File: rtl/ofs_counter_pkg.sv
package ofs_counter_pkg;

  typedef enum logic [1:0] {
    LD_EXT   = 2'd0,
    LD_START = 2'd1,
    LD_ZERO  = 2'd2
  } ldSrc_e;

  typedef struct packed {
    logic   clr;
    logic   ld;
    ldSrc_e ldSrc;
    logic   inc;
  } cntStrobe_t;

endpackage

// File: rtl/ofs_counter_ctrl.sv
module ofs_counter_ctrl
  import ofs_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clear,
  input  logic         load,
  input  logic         enable,
  input  logic         startEn,
  input  logic         endEn,
  input  logic [W-1:0] count,
  input  logic [W-1:0] endVal,
  output cntStrobe_t   strobe
);

  logic atTop;
  logic atEnd;
  logic terminal;

  assign atTop = &count;
  assign atEnd = (count == endVal);
  // compare bound wins over the all-ones bound when it is enabled
  assign terminal = endEn ? atEnd : (startEn & atTop);

  always_comb begin
    strobe       = '0;
    strobe.ldSrc = LD_EXT;
    if (clear) begin
      strobe.clr = 1'b1;
    end else if (load) begin
      strobe.ld = 1'b1;
    end else if (enable) begin
      if (terminal) begin
        strobe.ld    = 1'b1;
        strobe.ldSrc = startEn ? LD_START : LD_ZERO;
      end else begin
        strobe.inc = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ofs_counter_dpath.sv
module ofs_counter_dpath
  import ofs_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  cntStrobe_t   strobe,
  input  logic         enable,
  input  logic [W-1:0] loadVal,
  input  logic [W-1:0] startVal,
  output logic [W-1:0] count,
  output logic         carry
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cntQ;
  logic [W-1:0] ldData;

  always_comb begin
    unique case (strobe.ldSrc)
      LD_START: ldData = startVal;
      LD_ZERO:  ldData = '0;
      default:  ldData = loadVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) begin
      cntQ <= '0;
    end else if (strobe.ld) begin
      cntQ <= ldData;
    end else if (strobe.inc) begin
      cntQ <= cntQ + ONE;
    end
  end

  assign count = cntQ;
  assign carry = enable & (&cntQ);

endmodule

// File: rtl/ofs_counter.sv
module ofs_counter
  import ofs_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic         enable,
  input  logic [W-1:0] loadVal,
  input  logic         startEn,
  input  logic [W-1:0] startVal,
  input  logic         endEn,
  input  logic [W-1:0] endVal,
  output logic [W-1:0] count,
  output logic         carry
);

  cntStrobe_t strobe;

  ofs_counter_ctrl #(.W(W)) ctrl_i (
    .clear   (clear),
    .load    (load),
    .enable  (enable),
    .startEn (startEn),
    .endEn   (endEn),
    .count   (count),
    .endVal  (endVal),
    .strobe  (strobe)
  );

  ofs_counter_dpath #(.W(W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .enable   (enable),
    .loadVal  (loadVal),
    .startVal (startVal),
    .count    (count),
    .carry    (carry)
  );

endmodule

// File: rtl/ofs_counter_chk.sv
module ofs_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         clear,
  input logic         load,
  input logic         enable,
  input logic [W-1:0] loadVal,
  input logic         startEn,
  input logic [W-1:0] startVal,
  input logic         endEn,
  input logic [W-1:0] endVal,
  input logic [W-1:0] count,
  input logic         carry
);

  AST_RST_ZERO: assert property (@(posedge clk) rst |=> (count == '0)); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!clear && load) |=> (count == $past(loadVal))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load && !enable) |=> $stable(count)); // R4
  AST_PLAIN_ROLL: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load && carry && !startEn && !endEn) |=> (count == '0)); // R6
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load && enable && startEn && !endEn && (&count))
    |=> (count == $past(startVal))); // R7
  AST_END_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load && enable && !startEn && endEn && (count == endVal))
    |=> (count == '0)); // R8
  AST_BOTH_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load && enable && startEn && endEn && (count == endVal))
    |=> (count == $past(startVal))); // R9

endmodule

bind ofs_counter ofs_counter_chk #(.W(W)) chk_i (.*);

// File: tb/ofs_counter_tb_top.sv
module ofs_counter_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       clear = 1'b0, load = 1'b0, enable = 1'b0;
  logic [3:0] loadVal = '0, startVal = '0, endVal = '0;
  logic       startEn = 1'b0, endEn = 1'b0;
  logic [3:0] count;
  logic       carry;

  ofs_counter #(.W(4)) dut_i (
    .clk(clk), .rst(rst), .clear(clear), .load(load), .enable(enable),
    .loadVal(loadVal), .startEn(startEn), .startVal(startVal),
    .endEn(endEn), .endVal(endVal), .count(count), .carry(carry)
  );

  // 8-bit chain of two cores for R10
  logic       casEn = 1'b0;
  logic [3:0] loCnt, hiCnt;
  logic       loCarry, hiCarry;

  ofs_counter #(.W(4)) lo_i (
    .clk(clk), .rst(rst), .clear(1'b0), .load(1'b0), .enable(casEn),
    .loadVal(4'h0), .startEn(1'b0), .startVal(4'h0),
    .endEn(1'b0), .endVal(4'h0), .count(loCnt), .carry(loCarry)
  );
  ofs_counter #(.W(4)) hi_i (
    .clk(clk), .rst(rst), .clear(1'b0), .load(1'b0), .enable(loCarry),
    .loadVal(4'h0), .startEn(1'b0), .startVal(4'h0),
    .endEn(1'b0), .endVal(4'h0), .count(hiCnt), .carry(hiCarry)
  );

  int total = 0;
  int bad = 0;
  logic [3:0] model = '0;
  logic [7:0] casModel = '0;

  function automatic logic [3:0] nextCnt(logic [3:0] q, logic c, logic l,
      logic e, logic [3:0] lv, logic se, logic [3:0] sv, logic ee, logic [3:0] ev);
    if (c) return 4'h0;
    if (l) return lv;
    if (!e) return q;
    if (ee && q == ev) return se ? sv : 4'h0;
    if (!ee && se && q == 4'hF) return sv;
    return q + 4'h1;
  endfunction

  function automatic string tagOf(logic [3:0] q, logic c, logic l, logic e,
      logic se, logic ee, logic [3:0] ev);
    if (c) return "R2";
    if (l) return "R3";
    if (!e) return "R4";
    if (ee && q == ev) return se ? "R9" : "R8";
    if (!ee && se && q == 4'hF) return "R7";
    if (ee && q == 4'hF) return "R8";
    return "R5";
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic c, logic l, logic e, logic [3:0] lv,
      logic se, logic [3:0] sv, logic ee, logic [3:0] ev);
    logic [3:0] exp;
    string tag;
    @(negedge clk);
    clear = c; load = l; enable = e; loadVal = lv;
    startEn = se; startVal = sv; endEn = ee; endVal = ev;
    #1;
    check("R6", int'(carry), int'(e && model == 4'hF));
    exp = nextCnt(model, c, l, e, lv, se, sv, ee, ev);
    tag = tagOf(model, c, l, e, se, ee, ev);
    @(posedge clk);
    #1;
    check(tag, int'(count), int'(exp));
    model = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R0 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", int'(count), 0);
    check("R1", int'(carry), 0);
    rst = 1'b0;

    // R5 plain count through rollover, R6 carry at all ones
    step(0, 1, 0, 4'hE, 0, 0, 0, 0);           // load 14 while disabled (R3)
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    // R4 hold
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R2 clear beats load and enable
    step(0, 1, 0, 4'h9, 0, 0, 0, 0);
    step(1, 1, 1, 4'h5, 1, 4'h3, 1, 4'h9);
    // R3 load beats enable
    step(0, 1, 1, 4'hA, 0, 0, 0, 0);
    // R7 start-only: 14,15 -> 6
    step(0, 1, 0, 4'hE, 1, 4'h6, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, 4'h6, 0, 0);
    // R8 end-only: 12,13 -> 0
    step(0, 1, 0, 4'hC, 0, 0, 1, 4'hD);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 1, 4'hD);
    // R8 above the end value rolls through all ones
    step(0, 1, 0, 4'hE, 0, 0, 1, 4'h4);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 1, 4'h4);
    // R9 both bounds 3..9
    step(0, 1, 0, 4'h8, 1, 4'h3, 1, 4'h9);
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 1, 4'h3, 1, 4'h9);
    // R9 end value all ones with start bound
    step(0, 1, 0, 4'hE, 1, 4'h2, 1, 4'hF);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 4'h2, 1, 4'hF);

    // random mix
    begin
      logic se, ee;
      logic [3:0] sv, ev;
      se = 0; ee = 0; sv = 0; ev = 0;
      for (int i = 0; i < 800; i++) begin
        if (i % 40 == 0) begin
          se = 1'($urandom); ee = 1'($urandom);
          sv = 4'($urandom); ev = 4'($urandom);
        end
        step(($urandom % 25) == 0, ($urandom % 12) == 0, ($urandom % 4) != 0,
             4'($urandom), se, sv, ee, ev);
      end
    end

    // R10 chained 8-bit counter
    @(negedge clk);
    rst = 1'b1; enable = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    casModel = '0;
    for (int i = 0; i < 700; i++) begin
      logic e;
      @(negedge clk);
      e = (i < 300) ? 1'b1 : (($urandom % 3) != 0);
      casEn = e;
      @(posedge clk);
      #1;
      if (e) casModel = casModel + 8'h1;
      check("R10", int'({hiCnt, loCnt}), int'(casModel));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule